// File: doc/BRIEF.md
# Fetch Program Counter with Jump and Branch Redirect

This block holds the fetch address of a five-stage in-order pipeline whose instruction and data memories have separate ports. On every clock edge it loads a new address; there is no enable. The address for the next fetch comes from one of four sources:

- the step past the current address;
- a register target supplied by Decode, for indirect jumps and returns;
- an absolute word immediate supplied by Decode, for direct jumps and calls;
- a relative branch target that Execute forms from the incremented address that reached it plus a byte offset.

The chosen address drives the instruction memory in the same cycle, before the counter register, which saves one cycle of fetch latency. The same address is also stored in the register. The current address and its increment are driven out so that later stages can carry them. Decode redirects jumps, so a jump has one delay slot. Execute redirects branches, so a branch has two.

Top module: `pcu_fetch_pc`

## Requirements
- R1: While `rst` is high, `fetch_addr` equals the reset address 0x0000. At the first rising edge that sees `rst` high, `pc_cur` becomes 0x0000. The reset is synchronous and active high.
- R2: There is no enable. After every rising edge without reset, `pc_cur` equals the `fetch_addr` value from before that edge.
- R3: When none of `br_take`, `jmp_imm_sel` and `jmp_reg_sel` is set, `fetch_addr` is `pc_cur + 4`. `pc_seq` always equals `pc_cur + 4`.
- R4: When `jmp_imm_sel` is the highest-priority select that is set, `fetch_addr` is `jmp_imm` shifted left by 2, truncated to 16 bits.
- R5: When `jmp_reg_sel` is the only select that is set, `fetch_addr` is `reg_target` with bits [1:0] cleared.
- R6: When `br_take` is set, `fetch_addr` is `exe_seq_addr + br_off` with bits [1:0] cleared.
- R7: Priority among the selects: `br_take` beats `jmp_imm_sel`, and `jmp_imm_sel` beats `jmp_reg_sel`.
- R8: All additions wrap modulo 2^16. For example, 0xFFFC + 4 gives 0x0000.
- R9: Out of reset, bits [1:0] of `fetch_addr` are always 00, and the value follows the inputs in the same cycle with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| jmp_reg_sel | input | 1 | Decode: take the register target |
| jmp_imm_sel | input | 1 | Decode: take the absolute word immediate |
| br_take | input | 1 | Execute: take the relative branch target |
| reg_target | input | 16 | Register operand used as the jump address |
| jmp_imm | input | 16 | Word-index immediate of a direct jump |
| exe_seq_addr | input | 16 | Incremented address carried to Execute |
| br_off | input | 16 | Byte offset of a branch |
| pc_cur | output | 16 | Registered current fetch address |
| pc_seq | output | 16 | `pc_cur + 4` |
| fetch_addr | output | 16 | Same-cycle instruction memory address |

## Verification
The Execute stage can take a branch in the same cycle that Decode asks for a jump, because the jump belongs to a younger instruction in a branch delay slot. The bench provokes this by raising `br_take` together with one or both jump selects, with distinct targets on every source. It then judges the result by comparing `fetch_addr` with the branch target and, after the edge, `pc_cur` with that same value. A second case raises both jump selects without a branch and expects the immediate target.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [1:0] {
    SRC_SEQ = 2'd0,
    SRC_REG = 2'd1,
    SRC_IMM = 2'd2,
    SRC_BR  = 2'd3
  } pcu_src_e;
endpackage

// File: rtl/pcu_src_arb.sv
module pcu_src_arb
  import pcu_pkg::*;
(
  input  logic     br_take,
  input  logic     jmp_imm_sel,
  input  logic     jmp_reg_sel,
  output pcu_src_e src
);
  // The branch belongs to the older instruction, so it wins.
  always_comb begin
    if (br_take)          src = SRC_BR;
    else if (jmp_imm_sel) src = SRC_IMM;
    else if (jmp_reg_sel) src = SRC_REG;
    else                  src = SRC_SEQ;
  end
endmodule

// File: rtl/pcu_target_mux.sv
module pcu_target_mux
  import pcu_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int INSTR_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              rst,
  input  pcu_src_e          src,
  input  logic [ADDR_W-1:0] pc_q,
  input  logic [ADDR_W-1:0] reg_target,
  input  logic [ADDR_W-1:0] jmp_imm,
  input  logic [ADDR_W-1:0] exe_seq_addr,
  input  logic [ADDR_W-1:0] br_off,
  output logic [ADDR_W-1:0] seq_addr,
  output logic [ADDR_W-1:0] next_pc
);
  localparam int ALIGN_W = $clog2(INSTR_BYTES);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(INSTR_BYTES - 1);

  logic [ADDR_W-1:0] reg_tgt, imm_tgt, br_tgt;

  assign seq_addr = (pc_q + STEP) & ALIGN_MASK;
  assign reg_tgt  = reg_target & ALIGN_MASK;
  assign imm_tgt  = jmp_imm << ALIGN_W;
  assign br_tgt   = (exe_seq_addr + br_off) & ALIGN_MASK;

  always_comb begin
    if (rst) next_pc = RESET_ADDR;
    else begin
      unique case (src)
        SRC_BR:  next_pc = br_tgt;
        SRC_IMM: next_pc = imm_tgt;
        SRC_REG: next_pc = reg_tgt;
        default: next_pc = seq_addr;
      endcase
    end
  end
endmodule

// File: rtl/pcu_pc_reg.sv
module pcu_pc_reg #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RESET_ADDR;
    else     q <= d;
  end
endmodule

// File: rtl/pcu_fetch_pc.sv
module pcu_fetch_pc
  import pcu_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int INSTR_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              jmp_reg_sel,
  input  logic              jmp_imm_sel,
  input  logic              br_take,
  input  logic [ADDR_W-1:0] reg_target,
  input  logic [ADDR_W-1:0] jmp_imm,
  input  logic [ADDR_W-1:0] exe_seq_addr,
  input  logic [ADDR_W-1:0] br_off,
  output logic [ADDR_W-1:0] pc_cur,
  output logic [ADDR_W-1:0] pc_seq,
  output logic [ADDR_W-1:0] fetch_addr
);
  pcu_src_e          src;
  logic [ADDR_W-1:0] pc_q, nxt;

  pcu_src_arb u_arb (
    .br_take    (br_take),
    .jmp_imm_sel(jmp_imm_sel),
    .jmp_reg_sel(jmp_reg_sel),
    .src        (src)
  );

  pcu_target_mux #(
    .ADDR_W(ADDR_W), .INSTR_BYTES(INSTR_BYTES), .RESET_ADDR(RESET_ADDR)
  ) u_mux (
    .rst         (rst),
    .src         (src),
    .pc_q        (pc_q),
    .reg_target  (reg_target),
    .jmp_imm     (jmp_imm),
    .exe_seq_addr(exe_seq_addr),
    .br_off      (br_off),
    .seq_addr    (pc_seq),
    .next_pc     (nxt)
  );

  pcu_pc_reg #(.ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)) u_reg (
    .clk(clk), .rst(rst), .d(nxt), .q(pc_q)
  );

  // The fetch address leaves before the register to save a cycle.
  assign fetch_addr = nxt;
  assign pc_cur     = pc_q;
endmodule

// File: rtl/pcu_fetch_pc_chk.sv
module pcu_fetch_pc_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              jmp_reg_sel,
  input logic              jmp_imm_sel,
  input logic              br_take,
  input logic [ADDR_W-1:0] jmp_imm,
  input logic [ADDR_W-1:0] exe_seq_addr,
  input logic [ADDR_W-1:0] br_off,
  input logic [ADDR_W-1:0] pc_cur,
  input logic [ADDR_W-1:0] pc_seq,
  input logic [ADDR_W-1:0] fetch_addr
);
  p_reset_fetch_r1: assert property (@(posedge clk) rst |-> fetch_addr == '0);
  p_reset_load_r1:  assert property (@(posedge clk) rst |=> pc_cur == '0);
  p_load_every_cycle_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pc_cur == $past(fetch_addr));
  p_seq_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!br_take && !jmp_imm_sel && !jmp_reg_sel) |-> fetch_addr == pc_seq);
  p_imm_over_reg_r7: assert property (@(posedge clk) disable iff (rst)
    (!br_take && jmp_imm_sel) |-> fetch_addr == ADDR_W'({jmp_imm, 2'b00}));
  p_branch_wins_r6: assert property (@(posedge clk) disable iff (rst)
    br_take |-> fetch_addr[ADDR_W-1:2] == ADDR_W'(exe_seq_addr + br_off) >> 2);
  p_aligned_r9: assert property (@(posedge clk) disable iff (rst)
    fetch_addr[1:0] == 2'b00);
endmodule

bind pcu_fetch_pc pcu_fetch_pc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .jmp_reg_sel(jmp_reg_sel), .jmp_imm_sel(jmp_imm_sel),
  .br_take(br_take), .jmp_imm(jmp_imm), .exe_seq_addr(exe_seq_addr),
  .br_off(br_off), .pc_cur(pc_cur), .pc_seq(pc_seq), .fetch_addr(fetch_addr)
);

// File: tb/pcu_fetch_pc_bench.sv
module pcu_fetch_pc_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic jr = 1'b0, ji = 1'b0, br = 1'b0;
  logic [15:0] reg_target = '0, jmp_imm = '0, exe_seq_addr = '0, br_off = '0;
  logic [15:0] pc_cur, pc_seq, fetch_addr;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  pcu_fetch_pc u_pcu_fetch_pc (
    .clk(clk), .rst(rst), .jmp_reg_sel(jr), .jmp_imm_sel(ji), .br_take(br),
    .reg_target(reg_target), .jmp_imm(jmp_imm), .exe_seq_addr(exe_seq_addr),
    .br_off(br_off), .pc_cur(pc_cur), .pc_seq(pc_seq), .fetch_addr(fetch_addr)
  );

  typedef struct packed {
    logic [2:0]  sel;   // {br, ji, jr}
    logic [15:0] rt, ji_v, ex, off;
    logic [15:0] exp_fetch, exp_cur;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{3'b000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0004, 16'h0000}, // R3
    '{3'b000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0008, 16'h0004}, // R3
    '{3'b010, 16'h0000, 16'h0040, 16'h0000, 16'h0000, 16'h0100, 16'h0008}, // R4
    '{3'b001, 16'h2345, 16'h0000, 16'h0000, 16'h0000, 16'h2344, 16'h0100}, // R5
    '{3'b100, 16'h0000, 16'h0000, 16'h0010, 16'h0020, 16'h0030, 16'h2344}, // R6
    '{3'b111, 16'h8000, 16'h0011, 16'h1000, 16'hFFF8, 16'h0FF8, 16'h0030}, // R7
    '{3'b011, 16'h8000, 16'h0003, 16'h0000, 16'h0000, 16'h000C, 16'h0FF8}, // R7
    '{3'b100, 16'h0000, 16'h0000, 16'hFFFC, 16'h0008, 16'h0004, 16'h000C}, // R8
    '{3'b101, 16'h0400, 16'h0000, 16'h0100, 16'h0006, 16'h0104, 16'h0004}, // R6
    '{3'b010, 16'h0000, 16'hFFFF, 16'h0000, 16'h0000, 16'hFFFC, 16'h0104}, // R4
    '{3'b000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'hFFFC}, // R8
    '{3'b000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0004, 16'h0000}  // R2
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] s, input logic [15:0] r, input logic [15:0] i,
                       input logic [15:0] e, input logic [15:0] o);
    {br, ji, jr} = s;
    reg_target = r; jmp_imm = i; exe_seq_addr = e; br_off = o;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    check("R1 reset fetch", fetch_addr, 16'h0000);
    check("R1 reset pc", pc_cur, 16'h0000);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < NV; k++) begin
      drive(TBL[k].sel, TBL[k].rt, TBL[k].ji_v, TBL[k].ex, TBL[k].off);
      #1;
      check("R2 pc_cur", pc_cur, TBL[k].exp_cur);
      check("R3 pc_seq", pc_seq, TBL[k].exp_cur + 16'h0004);
      check("R9 fetch_addr", fetch_addr, TBL[k].exp_fetch);
      @(negedge clk);
    end
    // R9: same-cycle response with no clock edge in between
    drive(3'b010, 16'h0, 16'h0123, 16'h0, 16'h0);
    #1;
    check("R9 same cycle imm", fetch_addr, 16'h048C);
    drive(3'b001, 16'h7777, 16'h0, 16'h0, 16'h0);
    #1;
    check("R9 same cycle reg", fetch_addr, 16'h7774);
    @(negedge clk);
    check("R2 loaded reg target", pc_cur, 16'h7774);
    // R1: reset overrides a pending branch
    rst = 1'b1;
    drive(3'b100, 16'h0, 16'h0, 16'h4000, 16'h0040);
    #1;
    check("R1 reset beats branch", fetch_addr, 16'h0000);
    @(negedge clk);
    check("R1 pc after reset", pc_cur, 16'h0000);
    rst = 1'b0;
    drive(3'b000, 16'h0, 16'h0, 16'h0, 16'h0);
    #1;
    check("R3 restart", fetch_addr, 16'h0004);
    @(negedge clk);
    check("R2 restart pc", pc_cur, 16'h0004);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule